// File: doc/BRIEF.md
# Page-Mode DRAM Read Controller

This block sits between a CPU-side word read port and a small behavioural DRAM grid held inside the same module. Every read is turned into a sequence of row and column strobes on one shared, multiplexed address bus. A row strobe copies a whole row of the grid into an internal row buffer. A column strobe then picks one word out of that buffer and returns it to the requester. The controller remembers which row the buffer holds. A read that lands in that row is served with a column strobe alone, so a run of reads within one row costs one row strobe followed by a column strobe for each read.

A free-running refresh timer asks for a refresh row cycle at a fixed interval. The refresh cycle wins over any waiting read. It strobes the next row in a wrapping refresh sequence and leaves the buffer marked invalid, so the read that follows must open its row again. The grid contents come from a fixed computed pattern that is loaded at reset. The controller only reads.

Top module: `pagedram_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `rdata_valid`, `ras_o`, `cas_o` and `rfsh_o` are 0, and the row buffer counts as empty, so the first read performs a row strobe.
- R2: A read to a row other than the buffered row, or any read while the buffer is empty, raises `ras_o` for one cycle with the row index on `dram_addr`. This happens in the cycle after the handshake. The column strobe follows T_RCD+1 cycles later.
- R3: A read to the buffered row performs no row strobe. `cas_o` rises in the cycle after the handshake.
- R4: `rdata_valid` is a single-cycle pulse. With it, `rdata` carries the word at index i = row*4+col, whose value is (i*29+49) mod 256.
- R5: `rdata_valid` arrives T_CL+1 cycles after the column strobe. That is T_CL+2 cycles after the handshake on a hit and T_RCD+T_CL+3 cycles after it on a miss.
- R6: The read address splits into row = `req_addr[3:2]` and column = `req_addr[1:0]`. During the column strobe `dram_addr` carries the column index.
- R7: With no reads pending, refresh strobes (`ras_o` and `rfsh_o` both 1) occur every RFSH_PERIOD cycles. Their `dram_addr` runs 0,1,2,3,0,... from reset.
- R8: A due refresh takes priority over a read. `req_ready` is 0 during the refresh strobe, and the next read after a refresh performs a row strobe even if it targets the row that was buffered before.
- R9: `ras_o` and `cas_o` are never high together, and no column strobe immediately follows a row or refresh strobe.
- R10: Only one read is outstanding at a time. `req_ready` is 0 from the cycle after a handshake until that read's `rdata_valid` cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request |
| req_addr | input | 4 | Word address, row in upper bits, column in lower bits |
| req_ready | output | 1 | Controller can accept a read this cycle |
| rdata | output | 8 | Returned word, valid with rdata_valid |
| rdata_valid | output | 1 | One-cycle pulse marking returned data |
| dram_addr | output | 2 | Shared row/column address bus |
| ras_o | output | 1 | Row strobe (read or refresh) |
| cas_o | output | 1 | Column strobe |
| rfsh_o | output | 1 | Marks the current row strobe as a refresh |

## Verification
The bench keeps its own copy of the buffered-row state, fed by the strobes it observes. It then runs sequences that alternate page hits with row changes. A controller that ignores the open row would show extra row strobes and longer latency on hits. One that fails to compare the row would return data from the wrong row with no row strobe. After an idle stretch long enough for refreshes, the bench reads the row that was open before. A design that does not clear the buffer on refresh would answer with a column strobe alone. The refresh spacing and the wrapping refresh row sequence are also measured, which catches an off-by-one in the timer or in the pointer.

// File: rtl/pagedram_pkg.sv
// Package: shared types and the reset content pattern of the DRAM grid.
// Assumes callers truncate cell_seed to their own data width.
package pagedram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAS,
        ST_RCD,
        ST_CAS,
        ST_CL,
        ST_OUT,
        ST_RFSH
    } ctl_state_t;

    // Reset value of the cell at linear index idx (row*cols+col).
    function automatic int cell_seed(input int idx);
        return idx * 29 + 49;
    endfunction

endpackage

// File: rtl/dram_grid.sv
// Behavioural DRAM grid plus its internal row buffer.
// A load copies a full row into the buffer; the column output is a plain
// select out of the buffer. Contents are fixed at reset from cell_seed.
module dram_grid #(
    parameter int ROW_W  = 2,
    parameter int COL_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_load,
    input  logic [ROW_W-1:0]  row_sel,
    input  logic [COL_W-1:0]  col_sel,
    output logic [DATA_W-1:0] col_data
);
    localparam int ROWS = 1 << ROW_W;
    localparam int COLS = 1 << COL_W;

    logic [DATA_W-1:0] cells [ROWS][COLS];
    logic [DATA_W-1:0] rowbuf [COLS];

    // Hold the grid contents; loaded from the computed pattern on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    cells[r][c] <= DATA_W'(pagedram_pkg::cell_seed(r * COLS + c));
                end
            end
        end
    end

    // One buffer slot per column, each copying its column of the strobed row.
    for (genvar gc = 0; gc < COLS; gc++) begin : g_buf
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rowbuf[gc] <= '0;
            end else if (row_load) begin
                rowbuf[gc] <= cells[row_sel][gc];
            end
        end
    end

    // Column strobe selects one supercell from the buffer.
    assign col_data = rowbuf[col_sel];

endmodule

// File: rtl/page_tracker.sv
// Remembers which row sits in the row buffer and whether it is usable.
// Assumes set and clear are never requested in the same cycle.
module page_tracker #(
    parameter int ROW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_set,
    input  logic [ROW_W-1:0] open_row_in,
    input  logic             open_clear,
    input  logic [ROW_W-1:0] lookup_row,
    output logic             page_hit
);
    logic [ROW_W-1:0] open_row;
    logic             open_valid;

    // Track the open row; empty after reset and after every refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_row   <= '0;
            open_valid <= 1'b0;
        end else if (open_clear) begin
            open_valid <= 1'b0;
        end else if (open_set) begin
            open_row   <= open_row_in;
            open_valid <= 1'b1;
        end
    end

    // Hit when the buffer is valid and holds the requested row.
    assign page_hit = open_valid && (open_row == lookup_row);

endmodule

// File: rtl/rfsh_timer.sv
// Free-running refresh interval timer with a sticky request and a wrapping
// refresh row pointer. The request stays up until acknowledged.
module rfsh_timer #(
    parameter int RFSH_PERIOD = 64,
    parameter int ROW_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rfsh_ack,
    output logic             rfsh_pend,
    output logic [ROW_W-1:0] rfsh_row
);
    localparam int CNT_W = $clog2(RFSH_PERIOD + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RFSH_PERIOD - 1);

    logic [CNT_W-1:0] tick_cnt;
    logic             tick;

    assign tick = (tick_cnt == LAST);

    // Count cycles of one refresh interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (tick) begin
            tick_cnt <= '0;
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    // Raise the request on each interval end; a new tick beats an ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rfsh_pend <= 1'b0;
        end else if (tick) begin
            rfsh_pend <= 1'b1;
        end else if (rfsh_ack) begin
            rfsh_pend <= 1'b0;
        end
    end

    // Step to the next row after each refresh cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rfsh_row <= '0;
        end else if (rfsh_ack) begin
            rfsh_row <= rfsh_row + 1'b1;
        end
    end

endmodule

// File: rtl/pagedram_ctrl.sv
// Page-mode DRAM read controller. Accepts one word read at a time, issues
// a row strobe only when the buffered row differs, waits T_RCD and T_CL in
// their own states, and inserts refresh row cycles that take priority.
// Assumes T_RCD >= 1 and T_CL >= 1.
module pagedram_ctrl #(
    parameter int ROW_W       = 2,
    parameter int COL_W       = 2,
    parameter int DATA_W      = 8,
    parameter int T_RCD       = 2,
    parameter int T_CL        = 2,
    parameter int RFSH_PERIOD = 64,
    localparam int ADDR_W     = ROW_W + COL_W,
    localparam int MUX_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid,
    output logic [MUX_W-1:0]  dram_addr,
    output logic              ras_o,
    output logic              cas_o,
    output logic              rfsh_o
);
    import pagedram_pkg::*;

    localparam int WMAX   = (T_RCD > T_CL) ? T_RCD : T_CL;
    localparam int WAIT_W = $clog2(WMAX + 1);

    ctl_state_t        state;
    logic [WAIT_W-1:0] wait_cnt;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] col_data;
    logic              page_hit;
    logic              rfsh_pend;
    logic [ROW_W-1:0]  rfsh_row;
    logic [ROW_W-1:0]  in_row;
    logic [COL_W-1:0]  in_col;

    assign in_row = req_addr[ADDR_W-1:COL_W];
    assign in_col = req_addr[COL_W-1:0];

    dram_grid #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) grid_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_load (state == ST_RAS),
        .row_sel  (row_q),
        .col_sel  (col_q),
        .col_data (col_data)
    );

    page_tracker #(.ROW_W(ROW_W)) track_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_set    (state == ST_RAS),
        .open_row_in (row_q),
        .open_clear  (state == ST_RFSH),
        .lookup_row  (in_row),
        .page_hit    (page_hit)
    );

    rfsh_timer #(.RFSH_PERIOD(RFSH_PERIOD), .ROW_W(ROW_W)) rfsh_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rfsh_ack  (state == ST_RFSH),
        .rfsh_pend (rfsh_pend),
        .rfsh_row  (rfsh_row)
    );

    // Sequence strobes and wait states for each read or refresh cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wait_cnt <= '0;
            row_q    <= '0;
            col_q    <= '0;
            data_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (rfsh_pend) begin
                        state <= ST_RFSH;
                    end else if (req_valid) begin
                        row_q <= in_row;
                        col_q <= in_col;
                        state <= page_hit ? ST_CAS : ST_RAS;
                    end
                end
                ST_RAS: begin
                    wait_cnt <= WAIT_W'(T_RCD - 1);
                    state    <= ST_RCD;
                end
                ST_RCD: begin
                    if (wait_cnt == '0) begin
                        state <= ST_CAS;
                    end else begin
                        wait_cnt <= wait_cnt - 1'b1;
                    end
                end
                ST_CAS: begin
                    data_q   <= col_data;
                    wait_cnt <= WAIT_W'(T_CL - 1);
                    state    <= ST_CL;
                end
                ST_CL: begin
                    if (wait_cnt == '0) begin
                        state <= ST_OUT;
                    end else begin
                        wait_cnt <= wait_cnt - 1'b1;
                    end
                end
                ST_OUT:  state <= ST_IDLE;
                ST_RFSH: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the shared address bus and strobes from the current state.
    always_comb begin
        dram_addr = '0;
        unique case (state)
            ST_RAS:  dram_addr = MUX_W'(row_q);
            ST_CAS:  dram_addr = MUX_W'(col_q);
            ST_RFSH: dram_addr = MUX_W'(rfsh_row);
            default: dram_addr = '0;
        endcase
    end

    assign ras_o       = (state == ST_RAS) || (state == ST_RFSH);
    assign cas_o       = (state == ST_CAS);
    assign rfsh_o      = (state == ST_RFSH);
    assign req_ready   = (state == ST_IDLE) && !rfsh_pend;
    assign rdata_valid = (state == ST_OUT);
    assign rdata       = (state == ST_OUT) ? data_q : '0;

endmodule

// File: rtl/pagedram_ctrl_chk.sv
// Protocol checker for pagedram_ctrl, bound to every instance.
// Observes ports only.
module pagedram_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rdata_valid,
    input logic ras_o,
    input logic cas_o,
    input logic rfsh_o
);
    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ras_o && cas_o));

    a_r9_no_cas_after_ras: assert property (@(posedge clk) disable iff (!rst_n)
        ras_o |=> !cas_o);

    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid);

    a_r10_busy_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> !req_ready);

    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r8_refresh_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_o && rfsh_o) |-> !req_ready);

    a_r7_rfsh_is_row_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_o |-> ras_o);

endmodule

bind pagedram_ctrl pagedram_ctrl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rdata_valid (rdata_valid),
    .ras_o       (ras_o),
    .cas_o       (cas_o),
    .rfsh_o      (rfsh_o)
);

// File: tb/pagedram_ctrl_tb_top.sv
// Scoreboard bench: the read task pushes the expected word, a monitor pops
// and compares on rdata_valid; strobes are tracked against a bench model.
module pagedram_ctrl_tb_top;
    localparam int T_RCD  = 2;
    localparam int T_CL   = 2;
    localparam int PERIOD = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [3:0] req_addr = '0;
    logic       req_ready;
    logic [7:0] rdata;
    logic       rdata_valid;
    logic [1:0] dram_addr;
    logic       ras_o, cas_o, rfsh_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    bit         m_open = 1'b0;
    logic [1:0] m_row = '0;
    logic [1:0] m_rptr = '0;
    int         rf_n = 0;
    int         rf_t0 = 0, rf_t1 = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pagedram_ctrl #(.T_RCD(T_RCD), .T_CL(T_CL), .RFSH_PERIOD(PERIOD)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rdata(rdata), .rdata_valid(rdata_valid),
        .dram_addr(dram_addr), .ras_o(ras_o), .cas_o(cas_o), .rfsh_o(rfsh_o)
    );

    function automatic logic [7:0] exp_cell(input int idx);
        return 8'(idx * 29 + 49);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: scoreboard compare and refresh tracking.
    always @(negedge clk) begin
        if (rst_n && rdata_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected data", int'(rdata), -1);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                chk(rdata == e, "R4 data", int'(rdata), int'(e));
            end
        end
        if (rst_n && ras_o && rfsh_o) begin
            chk(dram_addr == m_rptr, "R7 refresh row", int'(dram_addr), int'(m_rptr));
            chk(req_ready == 1'b0, "R8 ready during refresh", int'(req_ready), 0);
            m_rptr = m_rptr + 1'b1;
            m_open = 1'b0;
            if (rf_n == 0) rf_t0 = cyc;
            if (rf_n == 1) rf_t1 = cyc;
            rf_n++;
        end
    end

    task automatic do_read(input logic [3:0] a, input string miss_tag);
        bit hit;
        int n;
        int ras_seen;
        req_addr  = a;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        hit = m_open && (m_row == a[3:2]);
        exp_q.push_back(exp_cell(int'(a)));
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        ras_seen = 0;
        forever begin
            if (ras_o && !rfsh_o) begin
                ras_seen++;
                chk(n == 1 && dram_addr == a[3:2], "R2 row strobe", int'(dram_addr), int'(a[3:2]));
            end
            if (cas_o) begin
                chk(dram_addr == a[1:0], "R6 column", int'(dram_addr), int'(a[1:0]));
                chk(n == (hit ? 1 : T_RCD + 2), hit ? "R3 cas timing" : "R2 cas timing",
                    n, hit ? 1 : T_RCD + 2);
            end
            if (rdata_valid) begin
                chk(n == (hit ? T_CL + 2 : T_RCD + T_CL + 3), "R5 latency",
                    n, hit ? T_CL + 2 : T_RCD + T_CL + 3);
                chk(req_ready == 1'b0, "R10 busy", int'(req_ready), 0);
                break;
            end
            if (n > 40) begin
                chk(1'b0, "R5 no data", n, 0);
                break;
            end
            n++;
            @(negedge clk);
        end
        chk(ras_seen == (hit ? 0 : 1), hit ? "R3 row strobes" : miss_tag,
            ras_seen, hit ? 0 : 1);
        m_open = 1'b1;
        m_row  = a[3:2];
        @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(rdata_valid == 1'b0, "R1 valid", int'(rdata_valid), 0);
        chk(!ras_o && !cas_o && !rfsh_o, "R1 strobes", int'({ras_o, cas_o, rfsh_o}), 0);
        do_read(4'h6, "R1 first read strobes");
        do_read(4'h7, "R2 row strobes");
        do_read(4'h4, "R2 row strobes");
        do_read(4'h5, "R2 row strobes");
        do_read(4'hB, "R2 row strobes");
        do_read(4'h8, "R2 row strobes");
        do_read(4'hF, "R2 row strobes");
        do_read(4'h0, "R2 row strobes");
        repeat (2 * PERIOD + 10) @(negedge clk);
        chk(rf_n >= 2, "R7 refresh count", rf_n, 2);
        chk(rf_t1 - rf_t0 == PERIOD, "R7 refresh spacing", rf_t1 - rf_t0, PERIOD);
        chk(m_open == 1'b0, "R8 buffer dropped", int'(m_open), 0);
        do_read(4'h1, "R8 reopen after refresh");
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 16; i++) do_read(4'(i), "R2 row strobes");
            for (int i = 15; i >= 0; i -= 5) do_read(4'(i), "R2 row strobes");
        end
        for (int i = 0; i < 60; i++) do_read(4'((i * 7) % 16), "R2 row strobes");
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all returned", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule